// File: doc/BRIEF.md
# Prescaled Coincidence Trigger Unit

This block makes the level-one trigger decision for a two-arm setup where each arm has a calorimeter and a row of scintillators. On every clock one sample arrives. A sample holds eight calorimeter amplitudes per arm and sixteen scintillator channels, which form eight scintillators with two channels each. The block sums these amplitudes and compares the sums with thresholds. This gives four arm flags: calorimeter-left (CL), calorimeter-right (CR), scintillator-left (SL) and scintillator-right (SR). From the flags it derives trigger sources and scaler conditions.

Three trigger sources exist: the calorimeter coincidence CL·CR, CL on its own and CR on its own. Each source goes through its own prescaler, and the survivors are ORed into a one-cycle trigger pulse. A three-bit pattern travels with the pulse and shows which sources fired.

Five conditions are counted in scalers:
- CL·CR
- CL·SL
- CR·SR
- the fourfold coincidence CL·CR·SL·SR
- a delayed coincidence: CL·CR with an SL·SR match seen a programmable number of samples earlier.

The scalers run between edges of an external helicity gate. At each gate edge the counts and the helicity bit are moved into a holding register, and counting starts again from zero. A three-state controller (idle, run, snapshot) sequences this.

Top module: `coinc_trig_unit`

## Requirements
- R1: CL is set for a sample when the sum of the eight `cal_left` amplitudes is strictly greater than `cal_thr`. CR is set the same way from `cal_right`. A sum equal to the threshold does not set the flag.
- R2: Scintillator k uses `scint` channels 2k and 2k+1. It hits when the sum of those two channels is strictly greater than `sc_thr`. SL is the OR of hits on scintillators 0 to 3, and SR is the OR of hits on scintillators 4 to 7.
- R3: `trig_why` bit 0 marks source CL·CR, bit 1 marks source CL and bit 2 marks source CR. `trig_out` is high in exactly the cycles where some `trig_why` bit is high. A qualifying sample captured at clock edge A shows on these outputs after the following edge B.
- R4: A source with prescale factor N passes the Nth, 2Nth, ... qualifying event and blocks the others. A factor of 0 or 1 passes every event.
- R5: Every source and every scaler condition is edge detected. A level that stays high for many samples gives one trigger and one count, and a `trig_why` bit is never high in two consecutive cycles.
- R6: `snap_counts` holds five fields of CW bits. Field i sits at bits [i*CW +: CW]. The fields are: 0 = CL·CR, 1 = CL·SL, 2 = CR·SR, 3 = CL·CR·SL·SR, 4 = delayed coincidence.
- R7: The delayed condition is CL·CR in the current sample together with SL·SR in the sample exactly D samples earlier. D is `dly_cfg` clamped to the range [MIN_DLY, MAX_DLY], which is [26, 64] by default.
- R8: Any level change of `hel_gate` is a gate edge. The controller moves between three states:
  - SC_IDLE is entered at reset, and no counting happens there. Its transition `go_run` on the first gate edge enters SC_RUN with no snapshot.
  - In SC_RUN, the transition `take_snap` on a gate edge copies the counts, and the `hel_bit` present at that edge, into the holding register. It then clears the counts and enters SC_SNAP.
  - SC_SNAP raises `snap_valid` for that cycle. It leaves by `resume` to SC_RUN, or by `take_snap` again on another edge.
  - An event whose rise coincides with a gate edge is counted in the new period.
- R9: While `rst_n` is low, `trig_out`, `trig_why`, `snap_valid`, `snap_hel` and `snap_counts` are zero, and the controller is in SC_IDLE.
- R10: `snap_counts` and `snap_hel` change only on a snapshot, so whenever `snap_valid` is low they hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_left | input | NCAL*AW | Left calorimeter amplitudes, channel i at [i*AW +: AW] |
| cal_right | input | NCAL*AW | Right calorimeter amplitudes |
| scint | input | 2*NSC*AW | Scintillator channels, channel j at [j*AW +: AW] |
| cal_thr | input | CSW | Calorimeter sum threshold |
| sc_thr | input | AW+1 | Scintillator pair-sum threshold |
| pre_both | input | PW | Prescale factor for CL·CR |
| pre_left | input | PW | Prescale factor for CL |
| pre_right | input | PW | Prescale factor for CR |
| dly_cfg | input | DW | Delay for the delayed coincidence, in samples |
| hel_gate | input | 1 | Helicity gate; each level change closes a period |
| hel_bit | input | 1 | Helicity bit stored with each snapshot |
| trig_out | output | 1 | One-cycle trigger pulse |
| trig_why | output | 3 | Sources that fired |
| snap_valid | output | 1 | High for one cycle after a snapshot |
| snap_hel | output | 1 | Helicity bit of the last snapshot |
| snap_counts | output | 5*CW | Held scaler values |

## Verification
Some behaviours are checked by assertions on every cycle:
- each source bit is a single-cycle pulse;
- a snapshot only follows a level change of the gate;
- the holding register is stable outside snapshots;
- the outputs are quiet in reset.

The directed scenarios cover what needs computed expectations:
- the strict threshold comparisons;
- the prescale decimation;
- the snapshot contents and the helicity bit;
- the assignment of an event that coincides with a gate edge;
- the exact sample offset and delay clamping of the delayed coincidence.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

    localparam int NUM_COND = 5;
    localparam int NUM_SRC  = 3;

    // scaler condition indices (field order in the snapshot)
    localparam int C_LR    = 0;
    localparam int C_LSL   = 1;
    localparam int C_RSR   = 2;
    localparam int C_QUAD  = 3;
    localparam int C_LATE  = 4;

    // trigger source indices (bit order of the cause pattern)
    localparam int S_BOTH  = 0;
    localparam int S_LEFT  = 1;
    localparam int S_RIGHT = 2;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_RUN  = 2'd1,
        SC_SNAP = 2'd2
    } scal_state_e;

endpackage

// File: rtl/ctu_arm_flags.sv
module ctu_arm_flags
    import ctu_pkg::*;
#(
    parameter int AW      = 12,
    parameter int NCAL    = 8,
    parameter int NSC     = 8,
    parameter int MIN_DLY = 26,
    parameter int MAX_DLY = 64,
    localparam int CSW    = AW + $clog2(NCAL),
    localparam int DW     = $clog2(MAX_DLY + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCAL*AW-1:0]    cal_left,
    input  logic [NCAL*AW-1:0]    cal_right,
    input  logic [2*NSC*AW-1:0]   scint,
    input  logic [CSW-1:0]        cal_thr,
    input  logic [AW:0]           sc_thr,
    input  logic [DW-1:0]         dly_cfg,
    output logic [NUM_COND-1:0]   cond,
    output logic [NUM_SRC-1:0]    src_lvl
);

    localparam int HALF = NSC / 2;

    logic [CSW-1:0] sum_l, sum_r;
    logic [AW:0]    pair_sum [NSC];
    logic [NSC-1:0] pair_hit;

    logic cl_q, cr_q, sl_q, sr_q;
    logic [MAX_DLY-1:0] late_sh;
    logic [DW-1:0]      d_eff;
    logic               late_hit;

    // calorimeter arm sums
    always_comb begin
        sum_l = '0;
        sum_r = '0;
        for (int i = 0; i < NCAL; i++) begin
            sum_l = sum_l + CSW'(cal_left[i*AW +: AW]);
            sum_r = sum_r + CSW'(cal_right[i*AW +: AW]);
        end
    end

    // per-scintillator two-channel sums
    for (genvar k = 0; k < NSC; k++) begin : g_pair
        assign pair_sum[k] = {1'b0, scint[(2*k)*AW +: AW]}
                           + {1'b0, scint[(2*k+1)*AW +: AW]};
        assign pair_hit[k] = (pair_sum[k] > sc_thr);
    end

    // registered arm flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cl_q <= 1'b0;
            cr_q <= 1'b0;
            sl_q <= 1'b0;
            sr_q <= 1'b0;
        end else begin
            cl_q <= (sum_l > cal_thr);
            cr_q <= (sum_r > cal_thr);
            sl_q <= |pair_hit[HALF-1:0];
            sr_q <= |pair_hit[NSC-1:HALF];
        end
    end

    // history of the scintillator coincidence; bit i is i+1 samples old
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            late_sh <= '0;
        end else begin
            late_sh <= {late_sh[MAX_DLY-2:0], (sl_q & sr_q)};
        end
    end

    // clamp the configured delay into the supported window
    always_comb begin
        if (dly_cfg < DW'(MIN_DLY)) begin
            d_eff = DW'(MIN_DLY);
        end else if (dly_cfg > DW'(MAX_DLY)) begin
            d_eff = DW'(MAX_DLY);
        end else begin
            d_eff = dly_cfg;
        end
    end

    always_comb begin
        late_hit = 1'b0;
        for (int i = 0; i < MAX_DLY; i++) begin
            if (d_eff == DW'(i + 1)) begin
                late_hit = late_sh[i];
            end
        end
    end

    always_comb begin
        cond[C_LR]   = cl_q & cr_q;
        cond[C_LSL]  = cl_q & sl_q;
        cond[C_RSR]  = cr_q & sr_q;
        cond[C_QUAD] = cl_q & cr_q & sl_q & sr_q;
        cond[C_LATE] = cl_q & cr_q & late_hit;
        src_lvl[S_BOTH]  = cl_q & cr_q;
        src_lvl[S_LEFT]  = cl_q;
        src_lvl[S_RIGHT] = cr_q;
    end

endmodule

// File: rtl/ctu_prescaler.sv
module ctu_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_lvl,
    input  logic [PW-1:0] factor,
    output logic          pass
);

    logic          prev_q;
    logic [PW-1:0] cnt_q;
    logic          rise;
    logic          at_last;

    assign rise    = src_lvl & ~prev_q;
    assign at_last = (factor <= PW'(1)) || (cnt_q >= factor - PW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
            pass   <= 1'b0;
        end else begin
            prev_q <= src_lvl;
            pass   <= 1'b0;
            if (rise) begin
                if (at_last) begin
                    pass  <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + PW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/ctu_scaler_bank.sv
module ctu_scaler_bank
    import ctu_pkg::*;
#(
    parameter int CW = 24,
    parameter int NC = NUM_COND
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC-1:0]    cond,
    input  logic             hel_gate,
    input  logic             hel_bit,
    output logic             snap_valid,
    output logic             snap_hel,
    output logic [NC*CW-1:0] snap_counts
);

    scal_state_e state_q, state_d;
    logic        gate_prev_q;
    logic        gate_edge;
    logic [NC-1:0] cond_prev_q;
    logic [NC-1:0] rise;

    assign gate_edge = hel_gate ^ gate_prev_q;
    assign rise      = cond & ~cond_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE: if (gate_edge) state_d = SC_RUN;
            SC_RUN:  if (gate_edge) state_d = SC_SNAP;
            SC_SNAP: state_d = gate_edge ? SC_SNAP : SC_RUN;
            default: state_d = SC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        snap_valid = 1'b0;
        unique case (state_q)
            SC_IDLE: snap_valid = 1'b0;
            SC_RUN:  snap_valid = 1'b0;
            SC_SNAP: snap_valid = 1'b1;
            default: snap_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_prev_q <= 1'b0;
            cond_prev_q <= '0;
            snap_hel    <= 1'b0;
        end else begin
            gate_prev_q <= hel_gate;
            cond_prev_q <= cond;
            if (gate_edge && state_q != SC_IDLE) begin
                snap_hel <= hel_bit;
            end
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_cnt
        logic [CW-1:0] run_q;
        logic [CW-1:0] hold_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q  <= '0;
                hold_q <= '0;
            end else begin
                if (state_q == SC_IDLE && !gate_edge) begin
                    run_q <= '0;
                end else if (gate_edge) begin
                    run_q <= CW'(rise[c]);
                end else begin
                    run_q <= run_q + CW'(rise[c]);
                end
                if (gate_edge && state_q != SC_IDLE) begin
                    hold_q <= run_q;
                end
            end
        end

        assign snap_counts[c*CW +: CW] = hold_q;
    end

endmodule

// File: rtl/coinc_trig_unit.sv
module coinc_trig_unit
    import ctu_pkg::*;
#(
    parameter int AW      = 12,
    parameter int NCAL    = 8,
    parameter int NSC     = 8,
    parameter int PW      = 16,
    parameter int CW      = 24,
    parameter int MIN_DLY = 26,
    parameter int MAX_DLY = 64,
    localparam int CSW    = AW + $clog2(NCAL),
    localparam int DW     = $clog2(MAX_DLY + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCAL*AW-1:0]       cal_left,
    input  logic [NCAL*AW-1:0]       cal_right,
    input  logic [2*NSC*AW-1:0]      scint,
    input  logic [CSW-1:0]           cal_thr,
    input  logic [AW:0]              sc_thr,
    input  logic [PW-1:0]            pre_both,
    input  logic [PW-1:0]            pre_left,
    input  logic [PW-1:0]            pre_right,
    input  logic [DW-1:0]            dly_cfg,
    input  logic                     hel_gate,
    input  logic                     hel_bit,
    output logic                     trig_out,
    output logic [NUM_SRC-1:0]       trig_why,
    output logic                     snap_valid,
    output logic                     snap_hel,
    output logic [NUM_COND*CW-1:0]   snap_counts
);

    logic [NUM_COND-1:0] cond;
    logic [NUM_SRC-1:0]  src_lvl;
    logic [NUM_SRC-1:0]  pass;
    logic [PW-1:0]       factor [NUM_SRC];

    assign factor[S_BOTH]  = pre_both;
    assign factor[S_LEFT]  = pre_left;
    assign factor[S_RIGHT] = pre_right;

    ctu_arm_flags #(
        .AW(AW), .NCAL(NCAL), .NSC(NSC),
        .MIN_DLY(MIN_DLY), .MAX_DLY(MAX_DLY)
    ) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cal_left (cal_left),
        .cal_right(cal_right),
        .scint    (scint),
        .cal_thr  (cal_thr),
        .sc_thr   (sc_thr),
        .dly_cfg  (dly_cfg),
        .cond     (cond),
        .src_lvl  (src_lvl)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_pre
        ctu_prescaler #(.PW(PW)) i_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_lvl(src_lvl[s]),
            .factor (factor[s]),
            .pass   (pass[s])
        );
    end

    assign trig_why = pass;
    assign trig_out = |pass;

    ctu_scaler_bank #(.CW(CW), .NC(NUM_COND)) i_scal (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond       (cond),
        .hel_gate   (hel_gate),
        .hel_bit    (hel_bit),
        .snap_valid (snap_valid),
        .snap_hel   (snap_hel),
        .snap_counts(snap_counts)
    );

endmodule

// File: rtl/ctu_checker.sv
module ctu_checker #(
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hel_gate,
    input logic          trig_out,
    input logic [2:0]    trig_why,
    input logic          snap_valid,
    input logic          snap_hel,
    input logic [5*CW-1:0] snap_counts
);

    // R9
    always @(posedge clk) begin
        reset_quiet_chk: assert (rst_n || (!trig_out && !snap_valid))
            else $error("outputs active during reset");
    end

    // R5
    why_both_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_why[0] |=> !trig_why[0]);

    // R5
    why_left_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_why[1] |=> !trig_why[1]);

    // R5
    why_right_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_why[2] |=> !trig_why[2]);

    // R8
    snap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |-> ($past(hel_gate) != $past(hel_gate, 2)));

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_valid |-> ($stable(snap_counts) && $stable(snap_hel)));

endmodule

bind coinc_trig_unit ctu_checker #(.CW(CW)) i_ctu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hel_gate   (hel_gate),
    .trig_out   (trig_out),
    .trig_why   (trig_why),
    .snap_valid (snap_valid),
    .snap_hel   (snap_hel),
    .snap_counts(snap_counts)
);

// File: tb/test_coinc_trig_unit.sv
module test_coinc_trig_unit;

    localparam int AW = 12;
    localparam int NCAL = 8;
    localparam int NSC = 8;
    localparam int PW = 16;
    localparam int CW = 24;
    localparam int CSW = AW + 3;
    localparam int DW = 7;
    localparam int HI = 1600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCAL*AW-1:0] cal_left = '0, cal_right = '0;
    logic [2*NSC*AW-1:0] scint = '0;
    logic [CSW-1:0] cal_thr = CSW'(1000);
    logic [AW:0] sc_thr = 13'd200;
    logic [PW-1:0] pre_both = 1, pre_left = 1, pre_right = 1;
    logic [DW-1:0] dly_cfg = 7'd30;
    logic hel_gate = 1'b0, hel_bit = 1'b0;
    logic trig_out;
    logic [2:0] trig_why;
    logic snap_valid, snap_hel;
    logic [5*CW-1:0] snap_counts;

    int checks = 0;
    int errors = 0;
    int trig_n = 0;
    logic [2:0] why_acc = '0;
    int snap_n = 0;
    logic [5*CW-1:0] snap_cap = '0;
    logic hel_cap = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    coinc_trig_unit i_coinc_trig_unit (
        .clk(clk), .rst_n(rst_n), .cal_left(cal_left), .cal_right(cal_right),
        .scint(scint), .cal_thr(cal_thr), .sc_thr(sc_thr),
        .pre_both(pre_both), .pre_left(pre_left), .pre_right(pre_right),
        .dly_cfg(dly_cfg), .hel_gate(hel_gate), .hel_bit(hel_bit),
        .trig_out(trig_out), .trig_why(trig_why), .snap_valid(snap_valid),
        .snap_hel(snap_hel), .snap_counts(snap_counts)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (trig_out) begin
                trig_n  = trig_n + 1;
                why_acc = why_acc | trig_why;
            end
            if (snap_valid) begin
                snap_n   = snap_n + 1;
                snap_cap = snap_counts;
                hel_cap  = snap_hel;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NCAL*AW-1:0] fill_arm(input int total);
        logic [NCAL*AW-1:0] v;
        for (int i = 0; i < NCAL; i++) begin
            v[i*AW +: AW] = AW'(total / NCAL + ((i == 0) ? total % NCAL : 0));
        end
        return v;
    endfunction

    task automatic set_sc(input int idx, input int a, input int b);
        scint[(2*idx)*AW +: AW]   = AW'(a);
        scint[(2*idx+1)*AW +: AW] = AW'(b);
    endtask

    // one-sample pulse; called right after a negedge, returns one negedge later
    task automatic pulse(input int cl_t, input int cr_t, input int sa, input int sb);
        cal_left  = fill_arm(cl_t);
        cal_right = fill_arm(cr_t);
        scint = '0;
        if (sa >= 0) set_sc(sa, 150, 60);
        if (sb >= 0) set_sc(sb, 150, 60);
        @(negedge clk);
        cal_left = '0;
        cal_right = '0;
        scint = '0;
    endtask

    function automatic longint field(input logic [5*CW-1:0] v, input int i);
        return longint'(v[i*CW +: CW]);
    endfunction

    task automatic toggle_gate(input logic hb);
        hel_bit  = hb;
        hel_gate = ~hel_gate;
    endtask

    task automatic t_reset;
        chk(trig_out == 1'b0, "R9", "trig_out in reset", trig_out, 0);
        chk(snap_valid == 1'b0, "R9", "snap_valid in reset", snap_valid, 0);
        chk(snap_counts == '0, "R9", "snap_counts in reset", 1, 0);
    endtask

    task automatic t_threshold;
        int n0;
        n0 = trig_n;
        pulse(1000, 1000, -1, -1);
        idle(4);
        chk(trig_n == n0, "R1", "sum equal to threshold triggers", trig_n - n0, 0);
        why_acc = '0;
        cal_left = fill_arm(1001);
        @(negedge clk);
        chk(trig_out == 1'b0, "R3", "trigger one edge after sample", trig_out, 0);
        cal_left = '0;
        @(negedge clk);
        chk(trig_out == 1'b1, "R3", "trigger two edges after sample", trig_out, 1);
        chk(trig_why == 3'b010, "R1", "left-only cause", trig_why, 3'b010);
        idle(3);
        why_acc = '0;
        pulse(0, 1001, -1, -1);
        idle(4);
        chk(why_acc == 3'b100, "R3", "right-only cause", why_acc, 3'b100);
        why_acc = '0;
        n0 = trig_n;
        pulse(HI, HI, -1, -1);
        idle(4);
        chk(why_acc == 3'b111, "R3", "both-arm cause", why_acc, 3'b111);
        chk(trig_n == n0 + 1, "R3", "one pulse for both-arm event", trig_n - n0, 1);
    endtask

    task automatic t_prescale;
        int n0;
        pre_left = 3;
        n0 = trig_n;
        for (int i = 0; i < 7; i++) begin
            pulse(HI, 0, -1, -1);
            idle(3);
        end
        chk(trig_n == n0 + 2, "R4", "factor 3 over 7 events", trig_n - n0, 2);
        pre_left = 0;
        n0 = trig_n;
        for (int i = 0; i < 2; i++) begin
            pulse(HI, 0, -1, -1);
            idle(3);
        end
        chk(trig_n == n0 + 2, "R4", "factor 0 passes all", trig_n - n0, 2);
        pre_left = 1;
    endtask

    task automatic t_scalers;
        int s0, n0;
        dly_cfg = 7'd30;
        s0 = snap_n;
        toggle_gate(1'b0);
        idle(4);
        chk(snap_n == s0, "R8", "first gate edge gives no snapshot", snap_n - s0, 0);
        // held level: one trigger, one count
        n0 = trig_n;
        cal_left = fill_arm(HI);
        cal_right = fill_arm(HI);
        idle(20);
        cal_left = '0;
        cal_right = '0;
        idle(4);
        chk(trig_n == n0 + 1, "R5", "held level triggers once", trig_n - n0, 1);
        pulse(HI, HI, -1, -1);
        idle(5);
        pulse(HI, HI, -1, -1);
        idle(5);
        pulse(HI, 0, 2, -1);            // left scint 2 hits: CL*SL
        idle(5);
        cal_left = fill_arm(HI);        // pair sum exactly 200: no hit
        set_sc(0, 100, 100);
        @(negedge clk);
        cal_left = '0;
        scint = '0;
        idle(5);
        pulse(HI, 0, 5, -1);            // right scint with left cal: no count
        idle(5);
        pulse(0, HI, 7, -1);            // CR*SR
        idle(5);
        pulse(HI, HI, 1, 4);            // fourfold
        idle(70);
        chk(snap_counts == '0, "R10", "holding unchanged before snapshot", 1, 0);
        s0 = snap_n;
        toggle_gate(1'b1);
        idle(3);
        chk(snap_n == s0 + 1, "R8", "one snapshot per edge", snap_n - s0, 1);
        chk(hel_cap == 1'b1, "R8", "helicity bit stored", hel_cap, 1);
        chk(field(snap_cap, 0) == 4, "R6", "CL*CR count", field(snap_cap, 0), 4);
        chk(field(snap_cap, 1) == 2, "R2", "CL*SL count", field(snap_cap, 1), 2);
        chk(field(snap_cap, 2) == 2, "R2", "CR*SR count", field(snap_cap, 2), 2);
        chk(field(snap_cap, 3) == 1, "R6", "fourfold count", field(snap_cap, 3), 1);
        chk(field(snap_cap, 4) == 0, "R7", "no delayed match", field(snap_cap, 4), 0);
        // event on the gate edge belongs to the new period
        idle(5);
        pulse(HI, HI, -1, -1);
        toggle_gate(1'b0);
        idle(3);
        chk(snap_cap == '0, "R8", "counts cleared, edge event excluded", field(snap_cap, 0), 0);
        chk(hel_cap == 1'b0, "R8", "helicity bit zero", hel_cap, 0);
        idle(5);
        toggle_gate(1'b1);
        idle(3);
        chk(field(snap_cap, 0) == 1, "R8", "edge event in new period", field(snap_cap, 0), 1);
    endtask

    task automatic t_delay;
        // delay 30: hit at 30, miss at 29; delay 5 clamps to 26: miss at 5, hit at 26
        dly_cfg = 7'd30;
        idle(5);
        toggle_gate(1'b0);
        idle(80);
        pulse(0, 0, 0, 4);
        idle(29);
        pulse(HI, HI, -1, -1);
        idle(80);
        pulse(0, 0, 0, 4);
        idle(28);
        pulse(HI, HI, -1, -1);
        idle(80);
        dly_cfg = 7'd5;
        pulse(0, 0, 0, 4);
        idle(4);
        pulse(HI, HI, -1, -1);
        idle(80);
        pulse(0, 0, 0, 4);
        idle(25);
        pulse(HI, HI, -1, -1);
        idle(80);
        toggle_gate(1'b1);
        idle(3);
        chk(field(snap_cap, 4) == 2, "R7", "delayed matches with clamp", field(snap_cap, 4), 2);
        chk(field(snap_cap, 0) == 4, "R6", "CL*CR during delay test", field(snap_cap, 0), 4);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        t_threshold();
        t_prescale();
        t_scalers();
        t_delay();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule